// File: doc/BRIEF.md
# Three-Stage In-Order Integer Pipeline with Software-Managed Delay Slots

This block is a small in-order integer core built from three clocked segments: fetch, operand/ALU, and execute/writeback. It runs a seven-operation instruction set. Two of the operations touch data memory: one reads a word into a register and one writes a register to memory. The others are add, subtract, increment, an absolute branch and an empty operation. The ALU operations work only between registers.

The hardware never stalls. A value read from memory reaches the register file one instruction too late for the next instruction, so that instruction still sees the old register contents. A branch redirects fetch only after the two instructions that follow it. Those two slots always run. The program places useful independent work or empty operations in them. An ALU result, by contrast, is forwarded to the very next instruction.

Instruction memory and data memory are outside the block. Each is expected to be a synchronous RAM with one cycle of read latency. The data memory has a separate read port and write port. A registered debug port lets a bench or a host read any register.

Top module: `slot_pipe3`

## Requirements
- R1: The k-th instruction fetched after reset performs its execute segment in cycle k+2, where cycle 1 is the first clock period after reset is released. A program of N instructions therefore finishes in N+2 cycles, and `imem_addr` advances by one each cycle unless a branch redirects it.
- R2: Reset sets the fetch address to 0 and fills both later segments with empty operations. In cycles 1 and 2 nothing is written to data memory, whatever `imem_rdata` holds.
- R3: Instruction word encoding. Bits [15:12] hold the opcode: 0 empty, 1 load, 2 store, 3 add, 4 subtract, 5 increment, 6 branch. Bits [11:8] hold the destination register, or the data-source register for a store. Bits [7:4] and [3:0] hold the source registers. Bits [7:0] hold the memory address for load and store and the absolute target for branch.
- R4: Add computes rs1+rs2, subtract computes rs1-rs2 and increment computes rs1+1. All three wrap modulo 2^XLEN and write the destination register.
- R5: The result of an add, subtract or increment is seen by the instruction immediately after it, including as store data.
- R6: The instruction immediately after a load reads the register value from before the load. The instruction two places after the load reads the loaded value.
- R7: A store reads its data register in the operand segment. It drives `dmem_we` high, with address and data, for exactly its execute cycle. A load presents its address on `dmem_raddr` in its operand segment and takes `dmem_rdata` one cycle later.
- R8: A branch fetched in cycle c causes the fetch in cycle c+3 to come from its target. The two instructions at the addresses after the branch always execute. The instruction after those two slots is never executed.
- R9: Opcodes 7 to 15 behave as the empty operation: they write no register and no memory.
- R10: `dbg_data` shows the register selected by `dbg_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Fetch address to instruction RAM (registered) |
| imem_rdata | input | 16 | Instruction word, one cycle after its address |
| dmem_raddr | output | 8 | Data RAM read address, valid while a load is in the operand segment |
| dmem_rdata | input | XLEN | Data RAM read word, one cycle after its address |
| dmem_we | output | 1 | Data RAM write enable (registered) |
| dmem_waddr | output | 8 | Data RAM write address (registered) |
| dmem_wdata | output | XLEN | Data RAM write data (registered) |
| dbg_addr | input | 4 | Register index for debug read |
| dbg_data | output | XLEN | Registered contents of the selected register |

## Verification
A table of load-load-empty-operate-store programs runs each ALU operation on ordinary operands and on wrap-around operands. These programs separate correct arithmetic from carry or borrow mistakes, and they pin the N+2 completion cycle. Separate programs then exercise specific cases:
- a load followed directly by a reader, which tells stale-read behaviour apart from an interlock or a forward;
- back-to-back ALU chains, which expose a missing forward path;
- the same branch with empty-operation slots and with filled slots, which must place the target's store in cycle 10 and cycle 8 and must skip the address after the slots;
- undefined opcodes, a store placed at address 0 right after reset, and a debug read whose value is sampled before and after the clock edge.

// File: rtl/slot_pipe3_pkg.sv
package slot_pipe3_pkg;

  // Instruction format widths (fixed by the encoding)
  localparam int INSW = 16;
  localparam int OPW  = 4;
  localparam int REGW = 4;
  localparam int FLDW = 8;
  localparam int NREG = 1 << REGW;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_ADD   = 4'd3,
    OP_SUB   = 4'd4,
    OP_INCR  = 4'd5,
    OP_JUMP  = 4'd6
  } op_e;

  typedef struct packed {
    op_e             op;
    logic [REGW-1:0] rd;
    logic [REGW-1:0] rs1;
    logic [REGW-1:0] rs2;
    logic [FLDW-1:0] fld;
  } dec_t;

  // Undefined opcodes fold into the empty operation
  function automatic op_e decode_op(input logic [OPW-1:0] raw);
    case (raw)
      4'd1:    return OP_LOAD;
      4'd2:    return OP_STORE;
      4'd3:    return OP_ADD;
      4'd4:    return OP_SUB;
      4'd5:    return OP_INCR;
      4'd6:    return OP_JUMP;
      default: return OP_NOP;
    endcase
  endfunction

  function automatic logic writes_alu(input op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INCR);
  endfunction

endpackage

// File: rtl/slot_pipe3_fetch.sv
module slot_pipe3_fetch #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redirect,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc,
  output logic          word_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc         <= '0;
      word_valid <= 1'b0;
    end else begin
      pc         <= redirect ? target : pc + 1'b1;
      word_valid <= 1'b1;
    end
  end

endmodule

// File: rtl/slot_pipe3_rf.sv
module slot_pipe3_rf #(
  parameter int XLEN = 16,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [XLEN-1:0]         wdata,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [XLEN-1:0]         rd1,
  output logic [XLEN-1:0]         rd2,
  input  logic [$clog2(NREG)-1:0] dbg_addr,
  output logic [XLEN-1:0]         dbg_data
);

  logic [XLEN-1:0] regs [NREG];

  // Write at the clock edge that closes the execute segment
  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

  always_ff @(posedge clk) begin
    if (rst) dbg_data <= '0;
    else     dbg_data <= regs[dbg_addr];
  end

endmodule

// File: rtl/slot_pipe3_alu.sv
module slot_pipe3_alu
  import slot_pipe3_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  op_e             op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_INCR: y = a + 1'b1;
      default: y = a;   // store passes its data operand through
    endcase
  end

endmodule

// File: rtl/slot_pipe3.sv
module slot_pipe3
  import slot_pipe3_pkg::*;
#(
  parameter int XLEN = 16
) (
  input  logic            clk,
  input  logic            rst,
  output logic [7:0]      imem_addr,
  input  logic [15:0]     imem_rdata,
  output logic [7:0]      dmem_raddr,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            dmem_we,
  output logic [7:0]      dmem_waddr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [3:0]      dbg_addr,
  output logic [XLEN-1:0] dbg_data
);

  localparam int AW = FLDW;

  // ---------------- fetch segment ----------------
  logic          word_valid;
  logic          redirect;
  logic [AW-1:0] e_fld;
  op_e           e_op;

  assign redirect = (e_op == OP_JUMP);

  slot_pipe3_fetch #(.AW(AW)) fetch_i (
    .clk        (clk),
    .rst        (rst),
    .redirect   (redirect),
    .target     (e_fld),
    .pc         (imem_addr),
    .word_valid (word_valid)
  );

  // ---------------- operand / ALU segment ----------------
  dec_t a_dec;
  op_e  a_op;

  always_comb begin
    a_dec.op  = word_valid ? decode_op(imem_rdata[15:12]) : OP_NOP;
    a_dec.rd  = imem_rdata[11:8];
    a_dec.rs1 = imem_rdata[7:4];
    a_dec.rs2 = imem_rdata[3:0];
    a_dec.fld = imem_rdata[7:0];
  end
  assign a_op = a_dec.op;

  logic [REGW-1:0] ra1;
  logic [XLEN-1:0] rd1, rd2, opa, opb, alu_y;
  logic            rf_we;
  logic [XLEN-1:0] rf_wdata;
  logic [REGW-1:0] e_rd;
  logic [XLEN-1:0] e_res;

  assign ra1 = (a_op == OP_STORE) ? a_dec.rd : a_dec.rs1;

  slot_pipe3_rf #(.XLEN(XLEN), .NREG(NREG)) rf_i (
    .clk      (clk),
    .rst      (rst),
    .we       (rf_we),
    .waddr    (e_rd),
    .wdata    (rf_wdata),
    .ra1      (ra1),
    .ra2      (a_dec.rs2),
    .rd1      (rd1),
    .rd2      (rd2),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  // Forward only ALU results; loaded data is deliberately not forwarded
  logic e_alu;
  assign e_alu = writes_alu(e_op);
  assign opa   = (e_alu && (e_rd == ra1))       ? e_res : rd1;
  assign opb   = (e_alu && (e_rd == a_dec.rs2)) ? e_res : rd2;

  slot_pipe3_alu #(.XLEN(XLEN)) alu_i (
    .op (a_op),
    .a  (opa),
    .b  (opb),
    .y  (alu_y)
  );

  // Load read issued from the operand segment
  assign dmem_raddr = a_dec.fld;

  // ---------------- execute / writeback segment ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      e_op    <= OP_NOP;
      dmem_we <= 1'b0;
    end else begin
      e_op    <= a_op;
      dmem_we <= (a_op == OP_STORE);
    end
  end

  always_ff @(posedge clk) begin
    e_rd       <= a_dec.rd;
    e_res      <= alu_y;
    e_fld      <= a_dec.fld;
    dmem_waddr <= a_dec.fld;
    dmem_wdata <= alu_y;
  end

  assign rf_we    = e_alu || (e_op == OP_LOAD);
  assign rf_wdata = (e_op == OP_LOAD) ? dmem_rdata : e_res;

endmodule

// File: rtl/slot_pipe3_chk.sv
module slot_pipe3_chk
  import slot_pipe3_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input op_e        a_op,
  input op_e        e_op,
  input logic [7:0] e_fld,
  input logic [7:0] imem_addr,
  input logic       dmem_we
);

  // R2
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dmem_we);

  // R8
  branch_redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (e_op == OP_JUMP) |=> (imem_addr == $past(e_fld)));

  // R1
  seq_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (e_op != OP_JUMP) |=> (imem_addr == $past(imem_addr) + 8'd1));

  // R7
  store_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (a_op == OP_STORE) |=> dmem_we);

  // R9
  no_stray_store_chk: assert property (@(posedge clk) disable iff (rst)
    (a_op != OP_STORE) |=> !dmem_we);

endmodule

bind slot_pipe3 slot_pipe3_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .a_op      (a_op),
  .e_op      (e_op),
  .e_fld     (e_fld),
  .imem_addr (imem_addr),
  .dmem_we   (dmem_we)
);

// File: tb/slot_pipe3_tb_top.sv
module slot_pipe3_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [7:0]      imem_addr;
  logic [15:0]     imem_q;
  logic [7:0]      dmem_raddr;
  logic [XLEN-1:0] dmem_q;
  logic            dmem_we;
  logic [7:0]      dmem_waddr;
  logic [XLEN-1:0] dmem_wdata;
  logic [3:0]      dbg_addr = '0;
  logic [XLEN-1:0] dbg_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_pipe3 #(.XLEN(XLEN)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_q),
    .dmem_raddr (dmem_raddr),
    .dmem_rdata (dmem_q),
    .dmem_we    (dmem_we),
    .dmem_waddr (dmem_waddr),
    .dmem_wdata (dmem_wdata),
    .dbg_addr   (dbg_addr),
    .dbg_data   (dbg_data)
  );

  // Synchronous RAM models, read-first
  logic [15:0]     imem [256];
  logic [XLEN-1:0] dmem [256];
  always @(posedge clk) begin
    imem_q <= imem[imem_addr];
    dmem_q <= dmem[dmem_raddr];
    if (dmem_we) dmem[dmem_waddr] <= dmem_wdata;
  end

  // Cycle counter: value k during cycle k after reset release
  int cyc;
  always @(posedge clk) begin
    if (rst) cyc <= 1;
    else     cyc <= cyc + 1;
  end

  // First-store capture
  logic            st_seen;
  int              st_cyc;
  logic [7:0]      st_addr;
  logic [XLEN-1:0] st_data;
  always @(negedge clk) begin
    if (!rst && dmem_we && !st_seen) begin
      st_seen = 1'b1;
      st_cyc  = cyc;
      st_addr = dmem_waddr;
      st_data = dmem_wdata;
    end
  end

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] enc_r(input logic [3:0] op, input logic [3:0] rd,
                                        input logic [3:0] rs1, input logic [3:0] rs2);
    return {op, rd, rs1, rs2};
  endfunction

  function automatic logic [15:0] enc_m(input logic [3:0] op, input logic [3:0] r,
                                        input logic [7:0] fld);
    return {op, r, fld};
  endfunction

  localparam logic [3:0] NOP = 4'd0, LD = 4'd1, ST = 4'd2, ADD = 4'd3,
                         SUB = 4'd4, INC = 4'd5, BR = 4'd6;

  task automatic clear_imem();
    for (int i = 0; i < 256; i++) imem[i] = 16'h0000;
  endtask

  task automatic halt_at(input int a);
    imem[a] = enc_m(BR, 4'd0, a[7:0]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    st_seen = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic read_reg(input logic [3:0] r, output logic [XLEN-1:0] v);
    @(negedge clk);
    dbg_addr = r;
    @(negedge clk);
    v = dbg_data;
  endtask

  typedef struct packed {
    logic [3:0]      op;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{op: 4'd3, a: 16'h0003, b: 16'h0004, exp: 16'h0007},
    '{op: 4'd3, a: 16'hFFFF, b: 16'h0001, exp: 16'h0000},
    '{op: 4'd4, a: 16'h0010, b: 16'h0003, exp: 16'h000D},
    '{op: 4'd4, a: 16'h0000, b: 16'h0001, exp: 16'hFFFF},
    '{op: 4'd5, a: 16'h7FFF, b: 16'h1234, exp: 16'h8000},
    '{op: 4'd5, a: 16'hFFFF, b: 16'h0000, exp: 16'h0000}
  };

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] v;
    for (int i = 0; i < 256; i++) dmem[i] = '0;
    clear_imem();

    // ---- R2 / R1: store at address 0 right after reset ----
    imem[0] = enc_m(ST, 4'd0, 8'h70);
    imem[1] = enc_m(BR, 4'd0, 8'h01);
    do_reset();
    #1;
    check("R2 fetch address 0 in cycle 1", imem_addr, 8'h00);
    @(negedge clk);
    check("R1 fetch address 1 in cycle 2", imem_addr, 8'h01);
    repeat (6) @(negedge clk);
    check("R2 first store cycle (none in cycles 1-2)", st_cyc, 3);
    check("R2 first store address", st_addr, 8'h70);

    // ---- R4 / R1 / R6: vector table, LOAD LOAD NOP OP STORE ----
    foreach (VECS[k]) begin
      clear_imem();
      dmem[8'h10] = VECS[k].a;
      dmem[8'h11] = VECS[k].b;
      imem[0] = enc_m(LD, 4'd1, 8'h10);
      imem[1] = enc_m(LD, 4'd2, 8'h11);
      imem[2] = 16'h0000;
      imem[3] = enc_r(VECS[k].op, 4'd3, 4'd1, 4'd2);
      imem[4] = enc_m(ST, 4'd3, 8'h20);
      halt_at(5);
      do_reset();
      repeat (12) @(negedge clk);
      check($sformatf("R4 vector %0d store data", k), st_data, VECS[k].exp);
      check($sformatf("R1 vector %0d N+2 completion", k), st_cyc, 7);
    end

    // ---- R6: stale read directly after a load ----
    clear_imem();
    dmem[8'h10] = 16'd5;
    dmem[8'h11] = 16'd100;
    imem[0] = enc_m(LD, 4'd1, 8'h10);
    imem[1] = 16'h0000;
    imem[2] = enc_m(LD, 4'd1, 8'h11);
    imem[3] = enc_r(ADD, 4'd2, 4'd1, 4'd1);
    imem[4] = enc_r(ADD, 4'd3, 4'd1, 4'd1);
    halt_at(5);
    do_reset();
    repeat (12) @(negedge clk);
    read_reg(4'd2, v);
    check("R6 reader after load sees old value", v, 16'd10);
    read_reg(4'd3, v);
    check("R6 second reader sees loaded value", v, 16'd200);

    // ---- R5 / R7: ALU forward chain and store data forward ----
    clear_imem();
    imem[0] = enc_m(LD, 4'd1, 8'h10);
    imem[1] = 16'h0000;
    imem[2] = enc_r(INC, 4'd1, 4'd1, 4'd0);
    imem[3] = enc_r(ADD, 4'd2, 4'd1, 4'd1);
    imem[4] = enc_r(SUB, 4'd3, 4'd2, 4'd1);
    imem[5] = enc_m(ST, 4'd3, 8'h22);
    halt_at(6);
    do_reset();
    repeat (12) @(negedge clk);
    read_reg(4'd2, v);
    check("R5 forwarded increment into add", v, 16'd12);
    check("R7 store data forwarded from subtract", st_data, 16'd6);
    check("R7 store in its execute cycle", st_cyc, 8);
    check("R7 memory written", dmem[8'h22], 16'd6);

    // ---- R8: branch with empty-operation slots ----
    clear_imem();
    dmem[8'h50] = '0;
    imem[0]     = enc_m(LD, 4'd1, 8'h10);
    imem[1]     = enc_r(INC, 4'd5, 4'd1, 4'd0);
    imem[2]     = enc_r(ADD, 4'd3, 4'd1, 4'd1);
    imem[3]     = enc_r(SUB, 4'd4, 4'd3, 4'd1);
    imem[4]     = enc_m(BR, 4'd0, 8'h40);
    imem[5]     = 16'h0000;
    imem[6]     = 16'h0000;
    imem[8'h40] = enc_m(ST, 4'd3, 8'h50);
    halt_at(8'h41);
    do_reset();
    repeat (16) @(negedge clk);
    check("R8 padded branch target completes cycle 10", st_cyc, 10);
    check("R8 padded branch target address", st_addr, 8'h50);

    // ---- R8: branch with filled slots; address 5 must be skipped ----
    clear_imem();
    dmem[8'h60] = '0;
    imem[0]     = enc_m(LD, 4'd1, 8'h10);
    imem[1]     = enc_r(INC, 4'd5, 4'd1, 4'd0);
    imem[2]     = enc_m(BR, 4'd0, 8'h40);
    imem[3]     = enc_r(ADD, 4'd3, 4'd1, 4'd1);
    imem[4]     = enc_r(SUB, 4'd4, 4'd3, 4'd1);
    imem[5]     = enc_m(ST, 4'd1, 8'h60);
    imem[8'h40] = enc_m(ST, 4'd3, 8'h50);
    halt_at(8'h41);
    do_reset();
    repeat (16) @(negedge clk);
    check("R8 filled branch target completes cycle 8", st_cyc, 8);
    check("R8 slot result stored at target", st_data, 16'd10);
    check("R8 address after slots not executed", dmem[8'h60], 16'd0);
    read_reg(4'd4, v);
    check("R8 second slot executed", v, 16'd5);

    // ---- R9 / R3: undefined opcodes act as empty operations ----
    clear_imem();
    imem[0] = enc_m(LD, 4'd1, 8'h10);
    imem[1] = 16'h0000;
    imem[2] = 16'hF111;
    imem[3] = 16'h7130;
    imem[4] = enc_m(ST, 4'd1, 8'h24);
    halt_at(5);
    do_reset();
    repeat (12) @(negedge clk);
    check("R9 undefined opcodes leave register", st_data, 16'd5);
    check("R9 undefined opcodes store nothing", st_addr, 8'h24);
    check("R3 store address field position", dmem[8'h24], 16'd5);

    // ---- R10: debug port latency ----
    read_reg(4'd1, v);
    @(negedge clk);
    dbg_addr = 4'd4;
    #1;
    check("R10 debug output before edge", dbg_data, 16'd5);
    @(negedge clk);
    check("R10 debug output after edge", dbg_data, 16'd5);
    dbg_addr = 4'd3;
    @(negedge clk);
    check("R10 debug new register", dbg_data, 16'd10);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule